// File: doc/BRIEF.md
# CAN Test-Mode Pin Control

This block sits between a CAN protocol core and the bus transceiver pins. It holds a small test configuration register and uses it to steer the transmit pin and the receive bit that the core sees. In normal operation it passes the core's transmit bit to the pin and the synchronized receive pin to the core. Under test it can force the transmit pin to either level, bring out the core's sample-point strobe on it, make the node silent, or loop the core's own transmit bit back into its receiver.

The register can only be written while the test-enable bit of the main control register is 1. While that bit is 0 the stored settings are kept and can still be read, but they have no effect on the pins. The RAM direct-access setting is stored here and exported on a port for the message RAM logic. The receive pin is synchronized by two flops before anything uses it. A read-only bit in the register shows the synchronized receive level.

Top module: `can_test_pinctl`

## Requirements
- R1: After reset all writable fields are 0. With the receive pin held recessive (1), the register reads 0x0000_0080.
- R2: A write changes the register only when wr_en_i and test_en_i are both 1 at the clock edge. With test_en_i at 0 the stored fields keep their value, and the new value is readable in the cycle after the edge.
- R3: Register layout: bit 9 RAM direct access, bit 8 external loopback, bit 7 receive monitor (read-only), bits 6:5 transmit select, bit 4 internal loopback, bit 3 silent. Every other bit reads 0, whatever was written.
- R4: Bit 7 of the read data equals rx_pin_i delayed by two clock edges. 0 means dominant and 1 means recessive.
- R5: While test_en_i is 0: tx_pin_o equals core_tx_i, core_rx_o equals the synchronized receive pin, and ram_direct_o is 0. The stored fields stay as they are and can still be read.
- R6: With test_en_i at 1 and transmit select 01, tx_pin_o equals core_smp_i.
- R7: With test_en_i at 1, transmit select 10 drives tx_pin_o to 0 and 11 drives it to 1. These settings take priority over silent and loopback.
- R8: With test_en_i at 1 and internal loopback set, core_rx_o equals core_tx_i. When transmit select is 00, tx_pin_o is 1. The external loopback bit has no effect in this mode.
- R9: With test_en_i at 1, silent set and transmit select 00, tx_pin_o is 1. Without internal loopback, core_rx_o comes from the synchronized receive pin.
- R10: With test_en_i at 1 and only external loopback set, tx_pin_o follows core_tx_i and core_rx_o comes from the synchronized receive pin.
- R11: ram_direct_o is the stored bit 9 ANDed with test_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_en_i | input | 1 | Test-enable bit from the main control register |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| core_tx_i | input | 1 | Transmit bit from the protocol core |
| core_smp_i | input | 1 | Sample-point strobe from the protocol core |
| core_rx_o | output | 1 | Receive bit presented to the protocol core |
| tx_pin_o | output | 1 | CAN transmit pin |
| rx_pin_i | input | 1 | CAN receive pin, asynchronous |
| ram_direct_o | output | 1 | RAM direct-access enable, gated by test enable |

## Verification
The assertions assume that test_en_i, wr_en_i, wr_data_i, core_tx_i and core_smp_i are synchronous to clk_i and settle before each rising edge. Only rx_pin_i may change at any time. The routing checks compare the pins with the register fields seen in the read data, so they assume the read port shows the live configuration. The bench changes every input only on the falling edge, including random receive levels, and checks the outputs two time units later. This keeps each stimulus inside those assumptions while it covers every mode combination.

// File: rtl/can_tst_pkg.sv
package can_tst_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned BIT_SILENT = 3;
  localparam int unsigned BIT_INT_LB = 4;
  localparam int unsigned BIT_TXS_LO = 5;
  localparam int unsigned BIT_TXS_HI = 6;
  localparam int unsigned BIT_RXMON  = 7;
  localparam int unsigned BIT_EXT_LB = 8;
  localparam int unsigned BIT_RAM_DA = 9;

  typedef enum logic [1:0] {
    TXS_CORE = 2'b00,
    TXS_SMP  = 2'b01,
    TXS_DOM  = 2'b10,
    TXS_REC  = 2'b11
  } tx_sel_e;

  typedef struct packed {
    logic    ram_da;
    logic    ext_lb;
    tx_sel_e tx_sel;
    logic    int_lb;
    logic    silent;
  } tst_cfg_t;
endpackage

// File: rtl/can_tst_rx_sync.sv
module can_tst_rx_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= RESET_VAL;
          else         sync_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[s] <= RESET_VAL;
          else         sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/can_tst_regs.sv
module can_tst_regs
  import can_tst_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rx_mon_i,
  output tst_cfg_t          cfg_o,
  output logic [DATA_W-1:0] rd_data_o
);
  tst_cfg_t cfg_q;
  logic     wr_ok;

  // writes are protected by the external test enable
  assign wr_ok = wr_en_i & test_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_ok) begin
      cfg_q.ram_da <= wr_data_i[BIT_RAM_DA];
      cfg_q.ext_lb <= wr_data_i[BIT_EXT_LB];
      cfg_q.tx_sel <= tx_sel_e'(wr_data_i[BIT_TXS_HI:BIT_TXS_LO]);
      cfg_q.int_lb <= wr_data_i[BIT_INT_LB];
      cfg_q.silent <= wr_data_i[BIT_SILENT];
    end
  end

  always_comb begin
    rd_data_o                        = '0;
    rd_data_o[BIT_RAM_DA]            = cfg_q.ram_da;
    rd_data_o[BIT_EXT_LB]            = cfg_q.ext_lb;
    rd_data_o[BIT_RXMON]             = rx_mon_i;
    rd_data_o[BIT_TXS_HI:BIT_TXS_LO] = cfg_q.tx_sel;
    rd_data_o[BIT_INT_LB]            = cfg_q.int_lb;
    rd_data_o[BIT_SILENT]            = cfg_q.silent;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/can_tst_route.sv
module can_tst_route
  import can_tst_pkg::*;
(
  input  logic    test_en_i,
  input  tx_sel_e tx_sel_i,
  input  logic    int_lb_i,
  input  logic    silent_i,
  input  logic    ram_da_i,
  input  logic    core_tx_i,
  input  logic    core_smp_i,
  input  logic    rx_sync_i,
  output logic    tx_pin_o,
  output logic    core_rx_o,
  output logic    ram_direct_o
);
  tx_sel_e act_sel;
  logic    act_int_lb;
  logic    act_silent;

  // stored settings are gated off while test mode is disabled
  assign act_sel      = test_en_i ? tx_sel_i : TXS_CORE;
  assign act_int_lb   = test_en_i & int_lb_i;
  assign act_silent   = test_en_i & silent_i;
  assign ram_direct_o = test_en_i & ram_da_i;

  assign core_rx_o = act_int_lb ? core_tx_i : rx_sync_i;

  always_comb begin
    unique case (act_sel)
      TXS_SMP:  tx_pin_o = core_smp_i;
      TXS_DOM:  tx_pin_o = 1'b0;
      TXS_REC:  tx_pin_o = 1'b1;
      default:  tx_pin_o = (act_int_lb | act_silent) ? 1'b1 : core_tx_i;
    endcase
  end
endmodule

// File: rtl/can_test_pinctl.sv
module can_test_pinctl
  import can_tst_pkg::*;
#(
  parameter int unsigned DATA_W      = REG_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              core_tx_i,
  input  logic              core_smp_i,
  output logic              core_rx_o,
  output logic              tx_pin_o,
  input  logic              rx_pin_i,
  output logic              ram_direct_o
);
  logic     rx_sync;
  tst_cfg_t cfg;

  can_tst_rx_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) i_rx_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_pin_i),
    .q_o   (rx_sync)
  );

  can_tst_regs #(
    .DATA_W(DATA_W)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .test_en_i(test_en_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .rx_mon_i (rx_sync),
    .cfg_o    (cfg),
    .rd_data_o(rd_data_o)
  );

  can_tst_route i_route (
    .test_en_i   (test_en_i),
    .tx_sel_i    (cfg.tx_sel),
    .int_lb_i    (cfg.int_lb),
    .silent_i    (cfg.silent),
    .ram_da_i    (cfg.ram_da),
    .core_tx_i   (core_tx_i),
    .core_smp_i  (core_smp_i),
    .rx_sync_i   (rx_sync),
    .tx_pin_o    (tx_pin_o),
    .core_rx_o   (core_rx_o),
    .ram_direct_o(ram_direct_o)
  );
endmodule

// File: rtl/can_test_pinctl_chk.sv
module can_test_pinctl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        test_en_i,
  input logic [31:0] rd_data_o,
  input logic        core_tx_i,
  input logic        core_smp_i,
  input logic        core_rx_o,
  input logic        tx_pin_o,
  input logic        rx_pin_i,
  input logic        ram_direct_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  assert_no_write_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |=> $stable({rd_data_o[9:8], rd_data_o[6:3]}));

  assert_reserved_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[31:10] == '0) && (rd_data_o[2:0] == '0));

  assert_rx_monitor_delay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (rd_data_o[7] == $past(rx_pin_i, 2)));

  assert_passthrough_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |-> (tx_pin_o == core_tx_i) && !ram_direct_o);

  assert_sample_point_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && rd_data_o[6:5] == 2'b01) |-> (tx_pin_o == core_smp_i));

  assert_forced_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && rd_data_o[6]) |-> (tx_pin_o == rd_data_o[5]));

  assert_int_loop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && rd_data_o[4]) |-> (core_rx_o == core_tx_i));

  assert_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_en_i && rd_data_o[3] && rd_data_o[6:5] == 2'b00) |-> tx_pin_o);

  assert_ram_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_direct_o == (test_en_i && rd_data_o[9]));
endmodule

bind can_test_pinctl can_test_pinctl_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .test_en_i   (test_en_i),
  .rd_data_o   (rd_data_o),
  .core_tx_i   (core_tx_i),
  .core_smp_i  (core_smp_i),
  .core_rx_o   (core_rx_o),
  .tx_pin_o    (tx_pin_o),
  .rx_pin_i    (rx_pin_i),
  .ram_direct_o(ram_direct_o)
);

// File: tb/test_can_test_pinctl.sv
module test_can_test_pinctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        test_en, wr_en, core_tx, core_smp, rx_pin;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        core_rx, tx_pin, ram_direct;

  int n_chk = 0;
  int n_err = 0;

  logic       m_ram, m_ext, m_int, m_sil, s1, s2;
  logic [1:0] m_txs;

  always #5 clk = ~clk;

  can_test_pinctl i_can_test_pinctl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .test_en_i   (test_en),
    .wr_en_i     (wr_en),
    .wr_data_i   (wr_data),
    .rd_data_o   (rd_data),
    .core_tx_i   (core_tx),
    .core_smp_i  (core_smp),
    .core_rx_o   (core_rx),
    .tx_pin_o    (tx_pin),
    .rx_pin_i    (rx_pin),
    .ram_direct_o(ram_direct)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_tx(input logic en, input logic ctx, input logic smp);
    if (!en) return ctx;
    case (m_txs)
      2'b01:   return smp;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return (m_int | m_sil) ? 1'b1 : ctx;
    endcase
  endfunction

  function automatic string tx_tag(input logic en);
    if (!en)             return "R5 tx";
    if (m_txs == 2'b01)  return "R6 tx";
    if (m_txs[1])        return "R7 tx";
    if (m_int)           return "R8 tx";
    if (m_sil)           return "R9 tx";
    return "R10 tx";
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] v = '0;
    v[9] = m_ram; v[8] = m_ext; v[7] = s2; v[6:5] = m_txs; v[4] = m_int; v[3] = m_sil;
    return v;
  endfunction

  task automatic step(input logic en, input logic we, input logic [31:0] wd,
                      input logic ctx, input logic smp, input logic rx);
    @(negedge clk);
    test_en = en; wr_en = we; wr_data = wd; core_tx = ctx; core_smp = smp; rx_pin = rx;
    #2;
    chk(tx_tag(en), {31'd0, tx_pin}, {31'd0, exp_tx(en, ctx, smp)});
    chk((en && m_int) ? "R8 rx" : (en && m_sil) ? "R9 rx" : "R10 R5 rx",
        {31'd0, core_rx}, {31'd0, (en && m_int) ? ctx : s2});
    chk("R2 R3 R4 R5 readback", rd_data, exp_rd());
    chk("R11 ram", {31'd0, ram_direct}, {31'd0, en & m_ram});
    @(posedge clk);
    if (en && we) begin
      m_ram = wd[9]; m_ext = wd[8]; m_txs = wd[6:5]; m_int = wd[4]; m_sil = wd[3];
    end
    s2 = s1; s1 = rx;
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; test_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    core_tx = 1'b1; core_smp = 1'b0; rx_pin = 1'b1;
    m_ram = 0; m_ext = 0; m_int = 0; m_sil = 0; m_txs = 2'b00; s1 = 1; s2 = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 reset readback", rd_data, 32'h0000_0080);
    chk("R1 reset tx", {31'd0, tx_pin}, 32'd1);

    // R2: write blocked while test enable is low
    step(0, 1, 32'hFFFF_FFFF, 0, 0, 1);
    step(0, 0, 32'h0, 1, 0, 1);
    // R3: all-ones write, reserved bits stay 0
    step(1, 1, 32'hFFFF_FFFF, 0, 1, 1);
    step(1, 0, 32'h0, 0, 1, 0);
    // R8: internal plus external loopback
    step(1, 1, 32'h0000_0110, 0, 0, 0);
    step(1, 0, 32'h0, 0, 0, 1);
    step(1, 0, 32'h0, 1, 1, 0);
    // R9: silent only
    step(1, 1, 32'h0000_0008, 0, 0, 0);
    step(1, 0, 32'h0, 0, 1, 1);
    // R10: external loopback only
    step(1, 1, 32'h0000_0100, 1, 0, 0);
    step(1, 0, 32'h0, 0, 0, 1);
    step(1, 0, 32'h0, 1, 0, 0);
    // R6: sample-point strobe
    step(1, 1, 32'h0000_0020, 1, 0, 1);
    step(1, 0, 32'h0, 0, 1, 1);
    step(1, 0, 32'h0, 0, 0, 1);
    // R7: forced dominant over silent and internal loopback
    step(1, 1, 32'h0000_0258, 1, 1, 0);
    step(1, 0, 32'h0, 1, 0, 0);
    // R5 R11: test enable off keeps the settings but gates them
    step(0, 1, 32'h0, 1, 1, 1);
    step(0, 0, 32'h0, 0, 1, 0);
    step(1, 0, 32'h0, 1, 0, 1);

    for (int i = 0; i < 600; i++) begin
      logic        en;
      logic        we;
      logic [31:0] wd;
      en = ($urandom % 4) != 0;
      we = ($urandom % 3) == 0;
      wd = $urandom;
      step(en, we, wd, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule